// File: doc/BRIEF.md
# Shift-Register Stepped Paged Program Counter

This block holds the instruction address of a small nibble-oriented controller. The address is split into a page field and a 6-bit in-page field. The in-page field does not count in binary. It moves through a fixed 64-state shift-register sequence, and that sequence includes the all-zero state. The page field never changes when the counter steps, so sequential code cannot run off the end of a 64-word page. A jump or a return loads the full address in one action.

A machine cycle spans four input clocks. An internal phase counter moves forward on each clock while the cycle enable is high. The counter acts only on the first phase of a cycle, which is the start of the instruction and comes before that instruction executes. The block keeps the address that was current before its latest update, so it can be observed. A combinational translator is also provided. It converts between a linear step number (0..63 within a page) and the real in-page address the sequence produces, in both directions.

Top module: `lfsr_paged_pc`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `pc_addr`, `pc_prev` and the phase counter are all cleared to zero.
- R2: The counter acts only at a cycle start, which is a rising edge where `cyc_en` is high and the phase is 0. The phase wraps 0,1,2,3,0. Requests presented during phases 1 to 3 have no effect.
- R3: A step forms the feedback bit f from two terms XORed together. The first term is 1 when bits [5:1] are all zero. The second term is bit1 XOR bit0. The new bits [5:0] are {f, old[5:1]}. From zero, the first step gives 0x20.
- R4: A step never changes bits [8:6] (the page).
- R5: Starting from any in-page value, 64 steps visit every one of the 64 in-page values exactly once and then return to the start.
- R6: Whenever the address changes at a cycle start, by a step or by a load, `pc_prev` takes the address held just before that change.
- R7: When `ld_req` is high at a cycle start, `pc_addr` takes `ld_addr`. Load wins over `adv_req` when both are high.
- R8: `xl_real_out` keeps bits [8:6] of `xl_lin_in` and replaces bits [5:0] with the in-page value reached after k steps from zero, where k is `xl_lin_in[5:0]`.
- R9: `xl_lin_out` keeps bits [8:6] of `xl_real_in` and gives in bits [5:0] the number of steps from zero needed to reach `xl_real_in[5:0]`. It is the inverse of R8.
- R10: While `cyc_en` is low, the phase holds and the address does not change, whatever the requests are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, four per machine cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_en | input | 1 | Clock enable for the phase counter |
| adv_req | input | 1 | Step the in-page address at the next cycle start |
| ld_req | input | 1 | Load `ld_addr` at the next cycle start |
| ld_addr | input | 9 | Jump target or return address |
| pc_addr | output | 9 | Current program address |
| pc_prev | output | 9 | Address held before the latest update |
| xl_lin_in | input | 9 | Page plus linear step number to translate |
| xl_real_out | output | 9 | Real address for `xl_lin_in` |
| xl_real_in | input | 9 | Page plus real in-page address to translate |
| xl_lin_out | output | 9 | Page plus linear step number for `xl_real_in` |

## Verification
The bench builds the block with its default parameters: a 9-bit address, a 6-bit in-page field and four phases per cycle. With these values a whole page period of 64 steps is short enough to walk completely, both in page 0 after reset and in the top page after a load. The four-phase setting makes it possible to hold requests in the non-start phases and show that they are ignored. The translator is checked for every one of the 64 step numbers against a sequence that the bench builds from the feedback rule.

// File: rtl/lfsr_pc_pkg.sv
// Package: shared sizing and the in-page step function.
// Assumes the step width is at least 2 bits.
package lfsr_pc_pkg;

    localparam int ADDR_W_DEF = 9;
    localparam int STEP_W_DEF = 6;
    localparam int PHASES_DEF = 4;

    // Advance one in-page value along the shift-register sequence.
    function automatic logic [STEP_W_DEF-1:0] step_next(input logic [STEP_W_DEF-1:0] cur);
        logic fb;
        fb = ((cur[STEP_W_DEF-1:1] == '0) ? 1'b1 : 1'b0) ^ cur[1] ^ cur[0];
        return {fb, cur[STEP_W_DEF-1:1]};
    endfunction

endpackage

// File: rtl/lfsr_pc_phase.sv
// Module: four-phase (parameterised) machine-cycle sequencer.
// Produces a one-clock strobe on the first phase of each machine cycle.
// Assumes PHASES >= 2; the phase holds while cyc_en is low.
module lfsr_pc_phase #(
    parameter int PHASES = 4,
    localparam int PH_W = (PHASES > 1) ? $clog2(PHASES) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cyc_en,
    output logic [PH_W-1:0] phase,
    output logic            cyc_start
);

    localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

    // Phase counter: wraps after the last phase, moves only when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (cyc_en)
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end

    // Cycle-start strobe: the first phase of an enabled cycle.
    assign cyc_start = cyc_en && (phase == '0);

endmodule

// File: rtl/lfsr_pc_core.sv
// Module: address registers for the program counter.
// Steps the in-page field at cycle start, keeps the page, loads on request.
// Assumes the in-page width matches the package step function.
module lfsr_pc_core
    import lfsr_pc_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    localparam int STEP_W = STEP_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_start,
    input  logic              adv_req,
    input  logic              ld_req,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic [ADDR_W-1:0] pc_addr,
    output logic [ADDR_W-1:0] pc_prev
);

    logic [ADDR_W-1:0] stepped;
    logic              update;

    // Next sequential address: page bits untouched, low field stepped.
    assign stepped = {pc_addr[ADDR_W-1:STEP_W], step_next(pc_addr[STEP_W-1:0])};
    assign update  = cyc_start && (ld_req || adv_req);

    // Current/previous address registers; load beats advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_addr <= '0;
            pc_prev <= '0;
        end else if (update) begin
            pc_prev <= pc_addr;
            pc_addr <= ld_req ? ld_addr : stepped;
        end
    end

endmodule

// File: rtl/lfsr_pc_xlate.sv
// Module: combinational translator between linear step number and real
// in-page address. The sequence table is derived from the step function.
// Assumes the step function has a full 2**STEP_W period.
module lfsr_pc_xlate
    import lfsr_pc_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    localparam int STEP_W = STEP_W_DEF,
    localparam int STEPS = 1 << STEP_W
) (
    input  logic [ADDR_W-1:0] lin_in,
    output logic [ADDR_W-1:0] real_out,
    input  logic [ADDR_W-1:0] real_in,
    output logic [ADDR_W-1:0] lin_out
);

    logic [STEP_W-1:0] seq [STEPS];
    logic [STEP_W-1:0] inv_idx;

    // Sequence table: entry k is the value after k steps from zero.
    assign seq[0] = '0;
    for (genvar k = 1; k < STEPS; k++) begin : g_seq
        assign seq[k] = step_next(seq[k-1]);
    end

    // Forward lookup keeps the page.
    assign real_out = {lin_in[ADDR_W-1:STEP_W], seq[lin_in[STEP_W-1:0]]};

    // Inverse lookup: find the step number holding the real value.
    always_comb begin
        inv_idx = '0;
        for (int k = 0; k < STEPS; k++)
            if (seq[k] == real_in[STEP_W-1:0])
                inv_idx = STEP_W'(k);
    end

    assign lin_out = {real_in[ADDR_W-1:STEP_W], inv_idx};

endmodule

// File: rtl/lfsr_paged_pc.sv
// Module: top of the paged program counter.
// Ties together the phase sequencer, the address registers and the
// translator. Assumes synchronous active-low reset.
module lfsr_paged_pc
    import lfsr_pc_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int PHASES = PHASES_DEF,
    localparam int PH_W = (PHASES > 1) ? $clog2(PHASES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_en,
    input  logic              adv_req,
    input  logic              ld_req,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic [ADDR_W-1:0] pc_addr,
    output logic [ADDR_W-1:0] pc_prev,
    input  logic [ADDR_W-1:0] xl_lin_in,
    output logic [ADDR_W-1:0] xl_real_out,
    input  logic [ADDR_W-1:0] xl_real_in,
    output logic [ADDR_W-1:0] xl_lin_out
);

    logic [PH_W-1:0] phase;
    logic            cyc_start;

    lfsr_pc_phase #(.PHASES(PHASES)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_en    (cyc_en),
        .phase     (phase),
        .cyc_start (cyc_start)
    );

    lfsr_pc_core #(.ADDR_W(ADDR_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_start (cyc_start),
        .adv_req   (adv_req),
        .ld_req    (ld_req),
        .ld_addr   (ld_addr),
        .pc_addr   (pc_addr),
        .pc_prev   (pc_prev)
    );

    lfsr_pc_xlate #(.ADDR_W(ADDR_W)) u_xlate (
        .lin_in   (xl_lin_in),
        .real_out (xl_real_out),
        .real_in  (xl_real_in),
        .lin_out  (xl_lin_out)
    );

endmodule

// File: rtl/lfsr_pc_chk.sv
// Module: property checker for the paged program counter, bound to the top.
module lfsr_pc_chk #(
    parameter int ADDR_W = 9,
    parameter int PH_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cyc_en,
    input logic              cyc_start,
    input logic [PH_W-1:0]   phase,
    input logic              adv_req,
    input logic              ld_req,
    input logic [ADDR_W-1:0] ld_addr,
    input logic [ADDR_W-1:0] pc_addr,
    input logic [ADDR_W-1:0] pc_prev
);

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_start |=> $stable(pc_addr) && $stable(pc_prev));

    a_r3_step_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && adv_req && !ld_req) |=> pc_addr[5:0] != $past(pc_addr[5:0]));

    a_r4_page_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && adv_req && !ld_req) |=> pc_addr[ADDR_W-1:6] == $past(pc_addr[ADDR_W-1:6]));

    a_r6_prev_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && (adv_req || ld_req)) |=> pc_prev == $past(pc_addr));

    a_r7_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && ld_req) |=> pc_addr == $past(ld_addr));

    a_r10_phase_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_en |=> $stable(phase));

endmodule

bind lfsr_paged_pc lfsr_pc_chk #(.ADDR_W(ADDR_W), .PH_W(PH_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_en    (cyc_en),
    .cyc_start (cyc_start),
    .phase     (phase),
    .adv_req   (adv_req),
    .ld_req    (ld_req),
    .ld_addr   (ld_addr),
    .pc_addr   (pc_addr),
    .pc_prev   (pc_prev)
);

// File: tb/sim_lfsr_paged_pc.sv
module sim_lfsr_paged_pc;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_en = 1'b0;
    logic       adv_req = 1'b0;
    logic       ld_req = 1'b0;
    logic [8:0] ld_addr = '0;
    logic [8:0] pc_addr, pc_prev;
    logic [8:0] xl_lin_in = '0, xl_real_out, xl_real_in = '0, xl_lin_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    lfsr_paged_pc u0 (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .adv_req(adv_req),
        .ld_req(ld_req), .ld_addr(ld_addr), .pc_addr(pc_addr), .pc_prev(pc_prev),
        .xl_lin_in(xl_lin_in), .xl_real_out(xl_real_out),
        .xl_real_in(xl_real_in), .xl_lin_out(xl_lin_out)
    );

    // Reference step written from the rule in R3.
    function automatic logic [5:0] ref_step(input logic [5:0] v);
        logic f;
        f = (v[5:1] == 5'd0) ^ v[1] ^ v[0];
        return {f, v[5:1]};
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge with phase 0: one full machine cycle.
    task automatic instr(input logic ld, input logic [8:0] a, input logic adv);
        ld_req = ld; ld_addr = a; adv_req = adv; cyc_en = 1'b1;
        repeat (4) @(negedge clk);
        ld_req = 1'b0; adv_req = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cyc_en = 1'b0; adv_req = 1'b0; ld_req = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Vector fields: {ld, ld_addr[8:0], adv, expected pc[8:0]}
    localparam int NV = 9;
    localparam logic [19:0] VEC [NV] = '{
        {1'b0, 9'h000, 1'b1, 9'h020},
        {1'b0, 9'h000, 1'b1, 9'h010},
        {1'b1, 9'h1C0, 1'b1, 9'h1C0},
        {1'b0, 9'h000, 1'b1, 9'h1E0},
        {1'b0, 9'h000, 1'b0, 9'h1E0},
        {1'b1, 9'h0A2, 1'b0, 9'h0A2},
        {1'b0, 9'h000, 1'b1, 9'h0B1},
        {1'b1, 9'h13F, 1'b0, 9'h13F},
        {1'b0, 9'h000, 1'b1, 9'h11F}
    };

    task automatic period_walk(input logic [2:0] pg);
        logic [63:0] seen;
        logic [8:0]  start;
        seen = '0;
        start = pc_addr;
        for (int n = 0; n < 64; n++) begin
            if (seen[pc_addr[5:0]]) check("R5 repeat", pc_addr, 9'h1FF);
            seen[pc_addr[5:0]] = 1'b1;
            instr(1'b0, 9'h000, 1'b1);
            check("R4 page", {pc_addr[8:6], 6'd0}, {pg, 6'd0});
        end
        check("R5 return", pc_addr, start);
        check("R5 coverage", {8'd0, &seen}, 9'd1);
    endtask

    initial begin
        logic [8:0] exp_prev, exp_pc;
        logic [5:0] tbl [64];
        do_reset();
        // R1: reset state
        check("R1 pc", pc_addr, 9'h000);
        check("R1 prev", pc_prev, 9'h000);

        // Vector walk: R3, R4, R6, R7
        exp_prev = 9'h000; exp_pc = 9'h000;
        for (int i = 0; i < NV; i++) begin
            instr(VEC[i][19], VEC[i][18:10], VEC[i][9]);
            if (VEC[i][19] || VEC[i][9]) exp_prev = exp_pc;
            exp_pc = VEC[i][8:0];
            check("R3/R7 vector pc", pc_addr, exp_pc);
            check("R6 vector prev", pc_prev, exp_prev);
        end

        // R2: requests in phases 1..3 ignored
        do_reset();
        adv_req = 1'b0; ld_req = 1'b0; cyc_en = 1'b1;
        @(negedge clk);
        adv_req = 1'b1; ld_req = 1'b1; ld_addr = 9'h155;
        repeat (3) @(negedge clk);
        adv_req = 1'b0; ld_req = 1'b0;
        check("R2 off-phase ignored", pc_addr, 9'h000);
        instr(1'b0, 9'h000, 1'b1);
        check("R2 start-phase step", pc_addr, 9'h020);

        // R10: enable low freezes phase and address
        cyc_en = 1'b0; adv_req = 1'b1; ld_req = 1'b1; ld_addr = 9'h0F0;
        repeat (8) @(negedge clk);
        adv_req = 1'b0; ld_req = 1'b0;
        check("R10 frozen", pc_addr, 9'h020);
        instr(1'b0, 9'h000, 1'b1);
        check("R10 resumes in phase", pc_addr, 9'h010);

        // R5/R4: full period from reset (page 0) and from the top page
        do_reset();
        period_walk(3'd0);
        instr(1'b1, 9'h1C0, 1'b0);
        period_walk(3'd7);

        // R8/R9: translator both ways
        tbl[0] = 6'd0;
        for (int k = 1; k < 64; k++) tbl[k] = ref_step(tbl[k-1]);
        for (int k = 0; k < 64; k++) begin
            xl_lin_in  = {3'(k % 8), 6'(k)};
            xl_real_in = {3'(7 - k % 8), tbl[k]};
            #1;
            check("R8 lin->real", xl_real_out, {3'(k % 8), tbl[k]});
            check("R9 real->lin", xl_lin_out, {3'(7 - k % 8), 6'(k)});
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule